// File: doc/BRIEF.md
# Lane Deserializer with Movable Load Edge

This block turns a source-synchronous serial bit stream into parallel words. Two related clocks drive it: a fast bit clock, and a slow word clock that runs at exactly 1/J of the bit clock's rate. Each serial bit enters a shift register on a falling edge of the bit clock. A counter in the bit-clock domain marks one falling edge in every group of J. On that edge the last J bits are copied into a holding register. Every rising edge of the word clock then copies the holding register into the output register that feeds the downstream logic.

After reset the copy happens on the third falling edge of each group. Two controls can move that edge. A static offset input adds a fixed displacement, taken modulo J. A one-cycle slip pulse adds one more position each time it is applied. A new load edge is adopted only at a word boundary, so the word that is being gathered when the edge moves is never broken up. The word width J can be set from 4 to 10, and 10 is the default. Ratios of 1 and 2 fall outside this block and are served by a separate bypass path.

Top module: `lane_deser`

## Requirements
- R1: Bits are taken on falling edges of `bitClk`, and the bit received first ends up in the most significant bit of `wordOut`.
- R2: While `rst` is high, the edge counter, the slip offset, the holding register and the output register are all cleared, so `wordValid` reads 0 and `wordOut` reads 0.
- R3: The edge counter counts falling edges after reset, numbered 0 to J-1, and then wraps to 0. With both offsets at zero, the load happens on edge 2 of each group, which is the third falling edge.
- R4: The load edge is (2 + `alignOfs` + slip offset) mod J. An `alignOfs` value of J or more also wraps modulo J.
- R5: Each `bitSlip` pulse, sampled on one falling edge, raises the slip offset by one modulo J. This moves the word boundary one bit later in the stream.
- R6: A new load edge takes effect only after the edge-counter wrap (counter value J-1). That wrap may be the same edge on which the slip is sampled. Loads before that wrap still use the old edge.
- R7: The holding register changes only on a load edge. `wordOut` copies it on every rising edge of `wordClk`, so a word loaded on a falling edge appears on the next rising edge of `wordClk`.
- R8: No load happens before J bits have been received since reset, which is before edge J-1. Until then `wordValid` stays 0 and `wordOut` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Fast bit clock; serial data is taken on its falling edge |
| wordClk | input | 1 | Slow word clock at 1/J of the bit rate, rising-edge aligned with `bitClk` |
| rst | input | 1 | Synchronous reset, active high, held for at least one word period |
| serIn | input | 1 | Serial data |
| alignOfs | input | $clog2(J) | Static load-edge displacement, added modulo J |
| bitSlip | input | 1 | One bit-clock-cycle pulse that advances the load edge by one |
| wordOut | output | J | Recovered word, first-received bit in the MSB |
| wordValid | output | 1 | High once a complete word has reached `wordOut` |

## Verification
The embedded properties check the cycle-level rules on every edge. They cover the counter stepping and wrapping, the slip offset rising by exactly one per pulse, the load edge staying fixed inside a word, the holding register staying untouched between loads, and a zero output while it is not valid. Only the bench scenarios can show that the recovered words are right. They confirm that the bit order matches the stream and that a given offset or sequence of slips lands the boundary on the sent words. They also check that the word taken in the group where a slip arrives still follows the old edge, and that the first valid word appears with the expected latency after reset.

// File: rtl/deser_pkg.sv
package deser_pkg;

  // Strobes passed from the edge-selection control to the datapath
  typedef struct packed {
    logic loadEn;    // current falling edge is the selected load edge
    logic complete;  // at least J bits have entered since reset
  } deserStrobe_t;

  // Modular sum used for edge arithmetic
  function automatic int modSum(input int a, input int b, input int c, input int m);
    return (a + b + c) % m;
  endfunction

endpackage

// File: rtl/deser_ctrl.sv
module deser_ctrl
  import deser_pkg::*;
#(
  parameter int J = 10,
  parameter int LOAD_EDGE = 2,
  localparam int OW = $clog2(J)
) (
  input  logic         bitClk,
  input  logic         rst,
  input  logic [OW-1:0] alignOfs,
  input  logic         bitSlip,
  output deserStrobe_t strobe
);

  localparam logic [OW-1:0] LAST_EDGE = OW'(J - 1);

  logic [OW-1:0] cnt;
  logic [OW-1:0] slipOfs;
  logic [OW-1:0] slipNext;
  logic [OW-1:0] loadEdge;
  logic [OW-1:0] edgeNext;
  logic [OW-1:0] edgeAtReset;
  logic          primed;
  logic          atWrap;

  assign atWrap = (cnt == LAST_EDGE);

  always_comb begin
    slipNext    = bitSlip ? OW'(modSum(int'(slipOfs), 1, 0, J)) : slipOfs;
    edgeNext    = OW'(modSum(LOAD_EDGE, int'(alignOfs), int'(slipNext), J));
    edgeAtReset = OW'(modSum(LOAD_EDGE, int'(alignOfs), 0, J));
  end

  // Edge counter, slip offset and word-boundary update of the load edge
  always_ff @(negedge bitClk) begin
    if (rst) begin
      cnt      <= '0;
      slipOfs  <= '0;
      loadEdge <= edgeAtReset;
      primed   <= 1'b0;
    end else begin
      cnt     <= atWrap ? '0 : cnt + 1'b1;
      slipOfs <= slipNext;
      if (atWrap) begin
        loadEdge <= edgeNext;
        primed   <= 1'b1;
      end
    end
  end

  always_comb begin
    strobe.loadEn   = (cnt == loadEdge);
    strobe.complete = primed || atWrap;
  end

  // R3
  cnt_wrap_chk: assert property (@(negedge bitClk) disable iff (rst)
    atWrap |=> (cnt == '0));

  // R3
  cnt_step_chk: assert property (@(negedge bitClk) disable iff (rst)
    !atWrap |=> (cnt == OW'($past(cnt) + 1'b1)));

  // R5
  slip_step_chk: assert property (@(negedge bitClk) disable iff (rst)
    bitSlip |=> (slipOfs == OW'((int'($past(slipOfs)) + 1) % J)));

  // R6
  edge_hold_chk: assert property (@(negedge bitClk) disable iff (rst)
    !atWrap |=> $stable(loadEdge));

  // R8
  primed_hold_chk: assert property (@(negedge bitClk) disable iff (rst)
    primed |=> primed);

endmodule

// File: rtl/deser_datapath.sv
module deser_datapath
  import deser_pkg::*;
#(
  parameter int J = 10
) (
  input  logic         bitClk,
  input  logic         wordClk,
  input  logic         rst,
  input  logic         serIn,
  input  deserStrobe_t strobe,
  output logic [J-1:0] wordOut,
  output logic         wordValid
);

  logic [J-2:0] history;   // the J-1 most recent bits
  logic [J-1:0] shiftNext; // history plus the bit taken on this edge
  logic [J-1:0] holdReg;
  logic         holdValid;
  logic         doLoad;

  assign shiftNext = {history, serIn};
  assign doLoad    = strobe.loadEn && strobe.complete;

  // Fast domain: shift on falling edge, load the holding register on the strobe
  always_ff @(negedge bitClk) begin
    if (rst) begin
      history   <= '0;
      holdReg   <= '0;
      holdValid <= 1'b0;
    end else begin
      history <= shiftNext[J-2:0];
      if (doLoad) begin
        holdReg   <= shiftNext;
        holdValid <= 1'b1;
      end
    end
  end

  // Slow domain: second capture stage
  always_ff @(posedge wordClk) begin
    if (rst) begin
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      wordOut   <= holdReg;
      wordValid <= holdValid;
    end
  end

  // R7
  hold_stable_chk: assert property (@(negedge bitClk) disable iff (rst)
    !doLoad |=> $stable(holdReg));

  // R8
  novalid_zero_chk: assert property (@(posedge wordClk) disable iff (rst)
    !wordValid |-> (wordOut == '0));

endmodule

// File: rtl/lane_deser.sv
module lane_deser
  import deser_pkg::*;
#(
  parameter int J = 10,
  parameter int LOAD_EDGE = 2,
  localparam int OW = $clog2(J)
) (
  input  logic          bitClk,
  input  logic          wordClk,
  input  logic          rst,
  input  logic          serIn,
  input  logic [OW-1:0] alignOfs,
  input  logic          bitSlip,
  output logic [J-1:0]  wordOut,
  output logic          wordValid
);

  deserStrobe_t strobe;

  deser_ctrl #(.J(J), .LOAD_EDGE(LOAD_EDGE)) ctrl (
    .bitClk  (bitClk),
    .rst     (rst),
    .alignOfs(alignOfs),
    .bitSlip (bitSlip),
    .strobe  (strobe)
  );

  deser_datapath #(.J(J)) datapath (
    .bitClk   (bitClk),
    .wordClk  (wordClk),
    .rst      (rst),
    .serIn    (serIn),
    .strobe   (strobe),
    .wordOut  (wordOut),
    .wordValid(wordValid)
  );

endmodule

// File: tb/tb_lane_deser.sv
module tb_lane_deser;

  localparam int J  = 10;
  localparam int AW = $clog2(J);

  logic          bitClk = 1'b0;
  logic          wordClk = 1'b0;
  logic          rst = 1'b1;
  logic          serIn = 1'b0;
  logic [AW-1:0] alignOfs = '0;
  logic          bitSlip = 1'b0;
  logic [J-1:0]  wordOut;
  logic          wordValid;

  int  checks = 0;
  int  failures = 0;
  int  curK = 0;         // index of the next falling edge after reset
  int  streamStart = 0;  // first bit index of word 0
  int  eOld = 2;
  int  eNew = 2;
  int  switchK = -1;     // last edge that still uses eOld
  bit  running = 1'b0;
  bit  done = 1'b0;
  int  phase = 0;

  lane_deser #(.J(J)) dut (
    .bitClk   (bitClk),
    .wordClk  (wordClk),
    .rst      (rst),
    .serIn    (serIn),
    .alignOfs (alignOfs),
    .bitSlip  (bitSlip),
    .wordOut  (wordOut),
    .wordValid(wordValid)
  );

  // 125 MHz bit clock
  always #4 bitClk = ~bitClk;

  // Word clock derived from the same source, rising with a bitClk rise
  initial begin
    forever begin
      @(posedge bitClk);
      phase   = (phase + 1) % J;
      wordClk = (phase < J / 2);
    end
  end

  function automatic logic [J-1:0] wordVal(input int n);
    return J'(n * 37 + 5);
  endfunction

  function automatic logic bitAt(input int k);
    logic [J-1:0] w;
    if (k < 0) return 1'b0;
    if (k < streamStart) return ((k * 7 + 3) % 5) < 2;
    w = wordVal((k - streamStart) / J);
    return w[J - 1 - ((k - streamStart) % J)];
  endfunction

  // The J bits ending at edge k, earliest in the MSB (R1)
  function automatic logic [J-1:0] window(input int k);
    logic [J-1:0] w;
    for (int i = 0; i < J; i++) w[J - 1 - i] = bitAt(k - J + 1 + i);
    return w;
  endfunction

  // Most recent loading edge at or before 'last', or -1 if none (R3..R6, R8)
  function automatic int lastLoad(input int last);
    int kNew;
    int lim;
    int kOld;
    if (last < 0) return -1;
    kNew = last - (((last - eNew) % J) + J) % J;
    if (kNew > switchK && kNew >= J - 1) return kNew;
    lim = (last < switchK) ? last : switchK;
    if (lim < 0) return -1;
    kOld = lim - (((lim - eOld) % J) + J) % J;
    return (kOld >= J - 1) ? kOld : -1;
  endfunction

  // Serial driver: new bit 1 ns after each falling edge
  always @(negedge bitClk) begin
    if (running) begin
      #1;
      curK  = curK + 1;
      serIn = bitAt(curK);
    end
  end

  task automatic checkOut(input string tag, input logic [J:0] exp);
    checks++;
    if ({wordValid, wordOut} !== exp) begin
      failures++;
      $display("FAIL %s: got valid=%0b word=%h, expected valid=%0b word=%h",
               tag, wordValid, wordOut, exp[J], exp[J-1:0]);
    end
  endtask

  task automatic startRun(input int s, input int align);
    running     = 1'b0;
    rst         = 1'b1;
    bitSlip     = 1'b0;
    alignOfs    = AW'(align);
    streamStart = s;
    curK        = 0;
    serIn       = bitAt(0);
    repeat (3 * J) @(posedge bitClk);
    #2;
    checkOut("R2 reset clears outputs", '0);
    @(posedge bitClk);
    #1;
    eOld    = (2 + align) % J;
    eNew    = eOld;
    switchK = -1;
    rst     = 1'b0;
    running = 1'b1;
  endtask

  task automatic checkWords(input int n, input string tag);
    int kk;
    repeat (n) begin
      @(posedge wordClk);
      #2;
      kk = lastLoad(curK - 1);
      if (kk < 0) checkOut(tag, '0);
      else checkOut(tag, {1'b1, window(kk)});
    end
  endtask

  task automatic checkAligned(input int n, input string tag);
    int kk;
    int off;
    repeat (n) begin
      @(posedge wordClk);
      #2;
      kk  = lastLoad(curK - 1);
      off = kk - streamStart - (J - 1);
      if (kk < 0 || off < 0 || (off % J) != 0) begin
        checks++;
        failures++;
        $display("FAIL %s: boundary not on a sent word, got word=%h, expected edge %0d", tag, wordOut, kk);
      end else begin
        checkOut(tag, {1'b1, wordVal(off / J)});
      end
    end
  endtask

  task automatic doSlip();
    int ks;
    @(posedge wordClk);
    #2;
    ks      = curK;
    bitSlip = 1'b1;
    eOld    = eNew;
    eNew    = (eNew + 1) % J;
    switchK = ks + (((J - 1 - ks) % J) + J) % J;
    @(posedge bitClk);
    #1;
    bitSlip = 1'b0;
  endtask

  // R3 R8: default third-edge load and first-word latency
  task automatic testFirstWord();
    startRun(0, 0);
    checkWords(6, "R3 R7 R8 default edge and first valid word");
  endtask

  // R1: words land MSB-first when the boundary matches
  task automatic testMsbFirst();
    startRun(3, 0);
    checkWords(2, "R8 startup");
    checkAligned(4, "R1 first bit in MSB");
  endtask

  // R4: static offset, including a value of J or more
  task automatic testAlignOffset();
    startRun(7, 4);
    checkWords(2, "R4 startup");
    checkAligned(4, "R4 offset aligns boundary");
    startRun(0, 13);
    checkWords(4, "R4 offset wraps modulo J");
  endtask

  // R5 R6: slips move the boundary one bit at a time, at the next word
  task automatic testBitslip();
    startRun(5, 0);
    checkWords(2, "R3 before slip");
    doSlip();
    checkWords(3, "R5 R6 first slip");
    doSlip();
    checkWords(3, "R5 R6 second slip");
    checkAligned(3, "R5 slips reach alignment");
  endtask

  // R5: offset wraps from edge J-1 to edge 0
  task automatic testSlipWrap();
    startRun(0, 7);
    checkWords(2, "R4 edge J-1");
    doSlip();
    checkWords(3, "R5 R6 slip wraps to edge 0");
  endtask

  // R2: a reset clears the accumulated slip offset
  task automatic testResetClearsSlip();
    startRun(3, 0);
    checkWords(2, "R2 startup");
    doSlip();
    checkWords(2, "R6 slip applied");
    startRun(3, 0);
    checkWords(2, "R2 startup after reset");
    checkAligned(2, "R2 offset cleared by reset");
  endtask

  initial begin
    testFirstWord();
    testMsbFirst();
    testAlignOffset();
    testBitslip();
    testSlipWrap();
    testResetClearsSlip();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Watchdog
  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: got running, expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule